// File: doc/BRIEF.md
# ATM Cell Header Screening Filter

The block looks at the first four header octets of each received ATM cell and decides, separately for four receive ports, whether that cell should be delivered to the port. Header bytes arrive one per clock on a byte bus with a qualifier and a start-of-cell flag. Once the fourth octet has been taken in, the block presents a four-bit accept bitmap together with a one-cycle valid strobe. Because the four ports are judged independently, a single cell may be accepted by any combination of ports, including all or none.

Each port holds a 32-bit header value and a 32-bit don't-care mask. Each one is split into two 16-bit registers that are written and read over a small synchronous register bus. A mask bit of one removes the matching header bit from the comparison. A port whose mask is entirely ones therefore accepts every cell. The filter settings used for a cell are copied when the cell's first octet arrives, so reprogramming during a cell never changes the verdict for that cell.

Top module: `cell_screen`

## Requirements
- R1: After reset every value register reads 0x0000, every mask register reads 0xFFFF, `accept_vld` is low, and the first cell is accepted by all four ports (`accept_map` = 4'b1111).
- R2: For port p (0..3), the value registers are at address 0x15+2p (octets 1/2) and 0x16+2p (octets 3/4), and the mask registers are at 0x1D+2p and 0x1E+2p. Within each register, bits 15..8 hold the earlier octet and bits 7..0 hold the later one. A write stores `reg_wdata`, and a read returns the stored word on `reg_rdata` in the same cycle.
- R3: Reads from any address outside 0x15..0x24 return 0x0000. Writes to such addresses leave every mapped register unchanged.
- R4: Where a mask bit is 0, port p accepts only if the header bit equals the value bit. A single differing bit rejects the cell.
- R5: Where a mask bit is 1, the header bit is ignored for port p.
- R6: Bit p of `accept_map` is the verdict for port p. Several bits may be set for the same cell.
- R7: A port whose mask is all ones accepts every cell, whatever its value registers hold.
- R8: `accept_vld` is high for exactly one cycle: the cycle after the clock edge that takes in octet 4. Bytes that follow octet 4 before the next start-of-cell produce no further result.
- R9: A start-of-cell byte that arrives before octet 4 drops the partial header without producing a result. That byte becomes octet 1 of a new cell.
- R10: Filter settings are copied at the edge that takes in octet 1. A register write in that cycle, or in any later cycle of the same cell, only affects later cells.
- R11: Only cycles with `rx_vld` high advance the octet count, so idle cycles between header bytes do not disturb the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| rx_byte | input | 8 | Received cell byte |
| rx_vld | input | 1 | `rx_byte` carries a byte this cycle |
| rx_soc | input | 1 | Byte is octet 1 of a cell (only meaningful with `rx_vld`) |
| accept_map | output | 4 | Per-port accept verdict, bit p for port p |
| accept_vld | output | 1 | One-cycle strobe qualifying `accept_map` |

## Verification
The bench sends headers that match one port exactly, headers that differ from a programmed value in a single unmasked bit, and headers that differ only in masked bits. This separates the exact-match path from the don't-care path. The same header is also screened by ports with overlapping settings and by a port left fully masked, which shows that the verdicts are independent and that a bitmap comes out rather than a single winner. Headers that contain idle gaps, trailing payload, or an early restart probe the octet counting. Register writes placed in the octet-1 cycle and in the middle of a cell show whether the settings copy is taken at the right edge.

// File: rtl/cscr_pkg.sv
// Shared sizes for the cell header screening filter.
package cscr_pkg;
    localparam int OCTET_W       = 8;
    localparam int HDR_OCTETS    = 4;
    localparam int HDR_W         = OCTET_W * HDR_OCTETS;
    localparam int REG_W         = 16;
    localparam int REGS_PER_PORT = HDR_W / REG_W;
endpackage

// File: rtl/cscr_regs.sv
// Register file holding the per-port header value and mask words.
// Assumes: two 16-bit words per port, value block followed directly by the
// mask block; earlier octet sits in the upper byte of each word.
module cscr_regs
    import cscr_pkg::*;
#(
    parameter int                NPORTS   = 4,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] VAL_BASE = 8'h15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [REG_W-1:0]        wdata,
    output logic [REG_W-1:0]        rdata,
    output logic [NPORTS*HDR_W-1:0] val_flat,
    output logic [NPORTS*HDR_W-1:0] msk_flat
);
    localparam int                NREG     = NPORTS * REGS_PER_PORT;
    localparam logic [ADDR_W-1:0] MSK_BASE = VAL_BASE + ADDR_W'(NREG);

    logic [REG_W-1:0] val_r [NREG];
    logic [REG_W-1:0] msk_r [NREG];
    logic [NREG-1:0]  val_sel, msk_sel;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign val_sel[i] = (addr == VAL_BASE + ADDR_W'(i));
        assign msk_sel[i] = (addr == MSK_BASE + ADDR_W'(i));

        // Hold one value word and one mask word; reset to match-everything.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_r[i] <= '0;
                msk_r[i] <= '1;
            end else if (wr_en) begin
                if (val_sel[i]) val_r[i] <= wdata;
                if (msk_sel[i]) msk_r[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_flat
        assign val_flat[p*HDR_W +: HDR_W] = {val_r[2*p], val_r[2*p+1]};
        assign msk_flat[p*HDR_W +: HDR_W] = {msk_r[2*p], msk_r[2*p+1]};
    end

    // Read mux: OR of the selected words, zero when nothing is selected.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (val_sel[i]) rdata = rdata | val_r[i];
            if (msk_sel[i]) rdata = rdata | msk_r[i];
        end
    end

    // Guard: an address that hits no register must read as zero.
    always_comb begin
        if (rst_n && (val_sel == '0) && (msk_sel == '0))
            a_r3_unmapped_zero: assert (rdata == '0);
    end
endmodule

// File: rtl/cscr_capture.sv
// Collects header octets 1..3 and flags the cycle in which octet 4 is on the bus.
// Assumes: rx_soc is only looked at when rx_vld is high; bytes after octet 4
// are ignored until the next start-of-cell.
module cscr_capture
    import cscr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCTET_W-1:0] byte_in,
    input  logic               byte_vld,
    input  logic               soc,
    output logic [HDR_W-1:0]   hdr_word,
    output logic               cell_start,
    output logic               hdr_last
);
    localparam int               CNT_W = $clog2(HDR_OCTETS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(HDR_OCTETS - 1);

    logic [OCTET_W-1:0] oct_r [HDR_OCTETS-1];
    logic [CNT_W-1:0]   cnt;
    logic               active;

    assign cell_start = byte_vld && soc;
    assign hdr_last   = byte_vld && !soc && active && (cnt == LAST);

    // Track the position inside the header; restart on every start-of-cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (cell_start) begin
            cnt    <= CNT_W'(1);
            active <= 1'b1;
        end else if (byte_vld && active) begin
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + CNT_W'(1);
        end
    end

    // Store octet 1 on start-of-cell.
    always_ff @(posedge clk) begin
        if (cell_start) oct_r[0] <= byte_in;
    end

    for (genvar k = 1; k < HDR_OCTETS - 1; k++) begin : g_oct
        // Store the middle octet k when its turn comes.
        always_ff @(posedge clk) begin
            if (byte_vld && !soc && active && (cnt == CNT_W'(k)))
                oct_r[k] <= byte_in;
        end
    end

    for (genvar k = 0; k < HDR_OCTETS - 1; k++) begin : g_word
        assign hdr_word[HDR_W-1-k*OCTET_W -: OCTET_W] = oct_r[k];
    end
    assign hdr_word[OCTET_W-1:0] = byte_in;

    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start |=> (active && cnt == CNT_W'(1)));
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_last |=> !active);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> ($stable(cnt) && $stable(active)));
endmodule

// File: rtl/cscr_port_match.sv
// One port's screen: the header passes when every unmasked bit equals the value.
// Assumes: mask bit 1 means don't care.
module cscr_port_match
    import cscr_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    input  logic [HDR_W-1:0] val,
    input  logic [HDR_W-1:0] msk,
    output logic             hit
);
    assign hit = ~|((hdr ^ val) & ~msk);

    // Guard the two limiting mask settings.
    always_comb begin
        if (&msk) a_r7_all_ones_pass: assert (hit);
        if (msk == '0) a_r4_exact: assert (hit == (hdr == val));
    end
endmodule

// File: rtl/cell_screen.sv
// Top of the header screening filter: register file, header capture, a
// settings copy taken at octet 1, one matcher per port and the result register.
// Assumes: one byte per clock when rx_vld is high; the result appears one
// cycle after octet 4.
module cell_screen
    import cscr_pkg::*;
#(
    parameter int                NPORTS   = 4,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] VAL_BASE = 8'h15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [OCTET_W-1:0] rx_byte,
    input  logic               rx_vld,
    input  logic               rx_soc,
    output logic [NPORTS-1:0]  accept_map,
    output logic               accept_vld
);
    localparam int FLAT_W = NPORTS * HDR_W;

    logic [FLAT_W-1:0] val_flat, msk_flat, snap_val, snap_msk;
    logic [HDR_W-1:0]  hdr_word;
    logic              cell_start, hdr_last;
    logic [NPORTS-1:0] hit_vec;

    cscr_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .VAL_BASE(VAL_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .val_flat(val_flat), .msk_flat(msk_flat)
    );

    cscr_capture u_cap (
        .clk(clk), .rst_n(rst_n), .byte_in(rx_byte), .byte_vld(rx_vld),
        .soc(rx_soc), .hdr_word(hdr_word), .cell_start(cell_start),
        .hdr_last(hdr_last)
    );

    // Copy the filter settings when octet 1 arrives so the cell sees one set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_val <= '0;
            snap_msk <= '1;
        end else if (cell_start) begin
            snap_val <= val_flat;
            snap_msk <= msk_flat;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        cscr_port_match u_m (
            .hdr(hdr_word),
            .val(snap_val[p*HDR_W +: HDR_W]),
            .msk(snap_msk[p*HDR_W +: HDR_W]),
            .hit(hit_vec[p])
        );
    end

    // Register the verdicts and the strobe on the octet-4 edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_vld <= 1'b0;
            accept_map <= '0;
        end else begin
            accept_vld <= hdr_last;
            if (hdr_last) accept_map <= hit_vec;
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        accept_vld |=> !accept_vld);
    a_r8_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        accept_vld |-> $past(rx_vld && !rx_soc));
    a_r10_copy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_start |=> ($stable(snap_val) && $stable(snap_msk)));
    a_r9_no_result_on_soc: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start |=> !accept_vld);
endmodule

// File: tb/sim_cell_screen.sv
`timescale 1ns/1ps
module sim_cell_screen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_vld = 1'b0;
    logic        rx_soc = 1'b0;
    logic [3:0]  accept_map;
    logic        accept_vld;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;
    logic [15:0] sh_val [8];
    logic [15:0] sh_msk [8];
    int    exp_map_q [$];
    int    exp_cyc_q [$];
    string exp_tag_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cell_screen u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_byte(rx_byte),
        .rx_vld(rx_vld), .rx_soc(rx_soc), .accept_map(accept_map),
        .accept_vld(accept_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [31:0] h);
        logic [3:0] m;
        for (int p = 0; p < 4; p++)
            m[p] = (((h ^ {sh_val[2*p], sh_val[2*p+1]}) & ~{sh_msk[2*p], sh_msk[2*p+1]}) == 0);
        return m;
    endfunction

    function automatic void shadow_write(input logic [7:0] a, input logic [15:0] d);
        if (a >= 8'h15 && a <= 8'h1C) sh_val[a - 8'h15] = d;
        else if (a >= 8'h1D && a <= 8'h24) sh_msk[a - 8'h1D] = d;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        shadow_write(a, d);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // Driver: sends one cell and queues its expected verdict.
    task automatic send_cell(input logic [31:0] h, input int npay, input bit gaps,
                             input string tag, input bit do_wr, input int wr_at,
                             input logic [7:0] wa, input logic [15:0] wd);
        logic [3:0] e;
        e = model(h);
        for (int i = 0; i < 4 + npay; i++) begin
            if (gaps && i > 0) begin
                @(posedge clk); #1;
                rx_vld = 1'b0; reg_we = 1'b0;
            end
            @(posedge clk); #1;
            rx_vld = 1'b1; rx_soc = (i == 0);
            rx_byte = (i < 4) ? h[31 - 8*i -: 8] : 8'(8'hA5 + i);
            reg_we = 1'b0;
            if (do_wr && i == wr_at) begin
                reg_we = 1'b1; reg_addr = wa; reg_wdata = wd;
                shadow_write(wa, wd);
            end
            if (i == 3) begin
                exp_map_q.push_back(int'(e));
                exp_cyc_q.push_back(cyc + 1);
                exp_tag_q.push_back(tag);
            end
        end
        @(posedge clk); #1;
        rx_vld = 1'b0; rx_soc = 1'b0; reg_we = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every strobe and compares.
    always @(negedge clk) begin
        if (rst_n && accept_vld) begin
            if (exp_map_q.size() == 0) begin
                check(1'b0, "R8/R9 unexpected strobe", 1, 0);
            end else begin
                int em, ec;
                string t;
                em = exp_map_q.pop_front();
                ec = exp_cyc_q.pop_front();
                t  = exp_tag_q.pop_front();
                check(accept_map == 4'(em), t, accept_map, em);
                check(cyc == ec, {"R8 timing ", t}, cyc, ec);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin sh_val[i] = '0; sh_msk[i] = '1; end
        repeat (4) @(posedge clk);
        #1;
        check(accept_vld == 1'b0, "R1 strobe low in reset", accept_vld, 0);
        rst_n = 1'b1;
        // R1 and R2: reset contents at every mapped address
        for (int p = 0; p < 4; p++) begin
            rd(8'(8'h15 + 2*p), 16'h0000, "R1 value reset");
            rd(8'(8'h16 + 2*p), 16'h0000, "R1 value reset");
            rd(8'(8'h1D + 2*p), 16'hFFFF, "R1 mask reset");
            rd(8'(8'h1E + 2*p), 16'hFFFF, "R1 mask reset");
        end
        send_cell(32'hDEADBEEF, 0, 0, "R1 accept all", 0, 0, 0, 0);
        // R3: unmapped space
        wr(8'h25, 16'h1234);
        wr(8'h14, 16'h5678);
        rd(8'h25, 16'h0000, "R3 read above map");
        rd(8'h14, 16'h0000, "R3 read below map");
        rd(8'h00, 16'h0000, "R3 read zero addr");
        rd(8'h24, 16'hFFFF, "R3 neighbour untouched");
        rd(8'h15, 16'h0000, "R3 neighbour untouched");
        // R2: program ports and read back
        wr(8'h15, 16'h1234); wr(8'h16, 16'h5678);
        wr(8'h1D, 16'h0000); wr(8'h1E, 16'h0000);
        wr(8'h17, 16'h1234); wr(8'h18, 16'h5600);
        wr(8'h1F, 16'h0000); wr(8'h20, 16'h00FF);
        wr(8'h19, 16'hABCD); wr(8'h1A, 16'h0000);
        wr(8'h21, 16'h0000); wr(8'h22, 16'h0000);
        wr(8'h1B, 16'h9999); wr(8'h1C, 16'h7777);
        rd(8'h15, 16'h1234, "R2 port0 value hi");
        rd(8'h18, 16'h5600, "R2 port1 value lo");
        rd(8'h20, 16'h00FF, "R2 port1 mask lo");
        rd(8'h19, 16'hABCD, "R2 port2 value hi");
        rd(8'h1B, 16'h9999, "R2 port3 value hi");
        rd(8'h23, 16'hFFFF, "R2 port3 mask hi");
        // R4..R7 screening patterns
        send_cell(32'h12345678, 0, 0, "R6 several ports", 0, 0, 0, 0);
        send_cell(32'h123456AA, 0, 0, "R5 masked bits", 0, 0, 0, 0);
        send_cell(32'h12345679, 0, 0, "R4 one bit off", 0, 0, 0, 0);
        send_cell(32'h92345678, 0, 0, "R4 top bit off", 0, 0, 0, 0);
        send_cell(32'hABCD0000, 0, 0, "R6 port2 only", 0, 0, 0, 0);
        send_cell(32'h00000000, 0, 0, "R7 all-ones port", 0, 0, 0, 0);
        // R11 gaps, R8 payload after header
        send_cell(32'h12345678, 0, 1, "R11 gaps", 0, 0, 0, 0);
        send_cell(32'hABCD0000, 6, 0, "R8 trailing payload", 0, 0, 0, 0);
        // R9: abandoned partial header then a full cell
        @(posedge clk); #1; rx_vld = 1'b1; rx_soc = 1'b1; rx_byte = 8'h12;
        @(posedge clk); #1; rx_soc = 1'b0; rx_byte = 8'h34;
        @(posedge clk); #1; rx_byte = 8'h56;
        send_cell(32'hABCD0000, 0, 0, "R9 restart", 0, 0, 0, 0);
        // R10: writes inside a cell apply from the next cell on
        send_cell(32'h12345678, 0, 0, "R10 mid-cell write", 1, 2, 8'h16, 16'h0000);
        send_cell(32'h12345678, 0, 0, "R10 next cell sees write", 0, 0, 0, 0);
        send_cell(32'h00000000, 0, 0, "R10 write at octet1", 1, 0, 8'h21, 16'hFFFF);
        send_cell(32'h00000000, 0, 0, "R10 write applied", 0, 0, 0, 0);
        repeat (5) @(posedge clk);
        #1;
        check(exp_map_q.size() == 0, "R8 missing results", exp_map_q.size(), 0);
        finish_run();
    end
endmodule